// File: doc/BRIEF.md
# L2 Home-Slice Remap Table

This block sits in the L1 miss path of one tile of a tiled multicore whose shared L2 cache is statically interleaved across the tiles by address. Every outgoing miss request carries a physical address. The bits just above the cache-line offset name the request's home L2 slice. The block uses that home ID to index a small active table, and the table entry becomes the request's destination slice. Software can therefore fold lightly used, distant slices onto a few nearby allocated ones, and the unused slices can be powered down. The lookup is purely combinational. The destination leaves in the same cycle as the request, so the miss path gains no latency. The handshake passes straight through the block with no storage.

The table is part of a process's context. At a context switch, software writes a shadow copy one entry at a time, together with an allocation mask that marks which slices are in service. It then issues a commit strobe. A small controller with four states, CFG_CLEAN, CFG_DIRTY, CFG_CHECK and CFG_FAULT, spends one cycle in CFG_CHECK checking the shadow copy. A legal table is copied into the active table in a single edge. An illegal one is dropped and raises a sticky error flag. The transitions are: CLEAN→DIRTY on a config write, CLEAN/DIRTY/FAULT→CHECK on commit, FAULT→DIRTY on a write, CHECK→CLEAN when legal, and CHECK→FAULT when illegal. A level input bypasses the table, and every request then goes to its home slice.

Top module: `slice_remap_unit`

## Requirements
- R1: With remapping enabled, the destination slice equals active-table entry h, where h is address bits [9:6] (a 4-bit home ID above the 6-bit line offset). The destination appears in the same cycle as the request.
- R2: With remapping disabled, the destination slice equals the home ID h, whatever the table holds.
- R3: The address, the valid bit and the ready bit pass through unchanged and combinationally.
- R4: After reset, the active and shadow tables are the identity, all 16 slices are allocated, and the error flag is 0.
- R5: Shadow writes do not affect the destination until a commit. A commit sampled at edge e enters the check state, and a legal table becomes visible after edge e+1.
- R6: A table in which an unallocated slice maps to an unallocated slice is rejected at commit. The active table is kept and the error flag is set.
- R7: A table in which an allocated slice does not map to itself is rejected in the same way.
- R8: The error flag stays set through further writes and failed commits, and is cleared only by a successful commit.
- R9: Entry writes, mask writes and commits presented during the check cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remap_en | input | 1 | 1: use the table; 0: identity bypass |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Ready back to the L1 controller |
| req_addr_i | input | 48 | Physical address of the miss |
| fwd_valid_o | output | 1 | Request valid toward the router |
| fwd_ready_i | input | 1 | Router ready |
| fwd_addr_o | output | 48 | Unchanged address |
| fwd_dest_o | output | 4 | Destination L2 slice |
| cfg_wr_en_i | input | 1 | Shadow entry write strobe |
| cfg_wr_idx_i | input | 4 | Entry (home slice) being written |
| cfg_wr_val_i | input | 4 | Destination slice for that entry |
| cfg_mask_wr_i | input | 1 | Allocation mask write strobe |
| cfg_mask_i | input | 16 | Allocation mask, bit j = slice j in service |
| cfg_commit_i | input | 1 | Check the shadow table and apply it if legal |
| cfg_err_o | output | 1 | Sticky rejected-commit flag |

## Verification
The bench checks the commit timing closely. A design that applies the table one edge early or one edge late shows the wrong destination in exactly one cycle. It also presents writes and commits during the check cycle. A design that accepts them would let an unchecked entry reach the active table, or would start a second check. It loads both kinds of illegal table and checks that requests still go to the old destinations, since a broken design would route to a powered-down slice. It also checks that the error flag survives more writes, because a flag cleared by a write would hide a rejected context load.

// File: rtl/remap_pkg.sv
package remap_pkg;
    typedef enum logic [1:0] {
        CFG_CLEAN = 2'd0,
        CFG_DIRTY = 2'd1,
        CFG_CHECK = 2'd2,
        CFG_FAULT = 2'd3
    } cfg_state_e;
endpackage

// File: rtl/remap_shadow.sv
module remap_shadow #(
    parameter int SLICE_W = 4,
    parameter int NSLICE  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic                        wr_en,
    input  logic [SLICE_W-1:0]          wr_idx,
    input  logic [SLICE_W-1:0]          wr_val,
    input  logic                        mask_wr,
    input  logic [NSLICE-1:0]           mask_val,
    output logic [NSLICE*SLICE_W-1:0]   shadow_flat,
    output logic [NSLICE-1:0]           shadow_mask,
    output logic                        legal
);
    logic [SLICE_W-1:0] tbl_q [NSLICE];
    logic [NSLICE-1:0]  mask_q;

    // one register per entry, reset to identity
    for (genvar g = 0; g < NSLICE; g++) begin : g_entry
        localparam logic [SLICE_W-1:0] SELF = SLICE_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[g] <= SELF;
            else if (accept && wr_en && (wr_idx == SELF))
                tbl_q[g] <= wr_val;
        end
        assign shadow_flat[g*SLICE_W +: SLICE_W] = tbl_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (accept && mask_wr)
            mask_q <= mask_val;
    end

    assign shadow_mask = mask_q;

    // legality: allocated -> self, unallocated -> some allocated slice
    always_comb begin
        legal = 1'b1;
        for (int j = 0; j < NSLICE; j++) begin
            if (mask_q[j]) begin
                if (tbl_q[j] != SLICE_W'(j)) legal = 1'b0;
            end else begin
                if (!mask_q[tbl_q[j]]) legal = 1'b0;
            end
        end
    end

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(shadow_flat) && $stable(shadow_mask))); // R9
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_touch,
    input  logic commit,
    input  logic legal,
    output logic accept,
    output logic apply,
    output logic err
);
    cfg_state_e state_q, state_d;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN: if (commit) state_d = CFG_CHECK;
                       else if (cfg_touch) state_d = CFG_DIRTY;
            CFG_DIRTY: if (commit) state_d = CFG_CHECK;
            CFG_CHECK: state_d = legal ? CFG_CLEAN : CFG_FAULT;
            CFG_FAULT: if (commit) state_d = CFG_CHECK;
                       else if (cfg_touch) state_d = CFG_DIRTY;
            default:   state_d = CFG_CLEAN;
        endcase
    end

    always_comb begin
        accept = (state_q != CFG_CHECK);
        apply  = (state_q == CFG_CHECK) && legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (apply)                          err_q <= 1'b0;
        else if (state_q == CFG_CHECK && !legal) err_q <= 1'b1;
    end

    assign err = err_q;

    AST_CHECK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_CHECK) |=> (state_q != CFG_CHECK)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !apply) |=> err_q); // R8
endmodule

// File: rtl/remap_active.sv
module remap_active #(
    parameter int SLICE_W = 4,
    parameter int NSLICE  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        apply,
    input  logic [NSLICE*SLICE_W-1:0]   shadow_flat,
    input  logic [NSLICE-1:0]           shadow_mask,
    input  logic [SLICE_W-1:0]          lookup_idx,
    output logic [SLICE_W-1:0]          lookup_dest
);
    localparam int TBL_W = NSLICE * SLICE_W;

    function automatic logic [TBL_W-1:0] ident_table();
        logic [TBL_W-1:0] t;
        for (int j = 0; j < NSLICE; j++) t[j*SLICE_W +: SLICE_W] = SLICE_W'(j);
        return t;
    endfunction

    logic [TBL_W-1:0]  act_q;
    logic [NSLICE-1:0] act_mask_q;
    logic              self_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= ident_table();
            act_mask_q <= '1;
        end else if (apply) begin
            act_q      <= shadow_flat;
            act_mask_q <= shadow_mask;
        end
    end

    assign lookup_dest = act_q[lookup_idx*SLICE_W +: SLICE_W];

    always_comb begin
        self_ok = 1'b1;
        for (int j = 0; j < NSLICE; j++)
            if (act_mask_q[j] && (act_q[j*SLICE_W +: SLICE_W] != SLICE_W'(j))) self_ok = 1'b0;
    end

    AST_HOLD_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_q)); // R5
    AST_DEST_ALLOCATED: assert property (@(posedge clk) disable iff (!rst_n)
        act_mask_q[lookup_dest]); // R6
    AST_ALLOC_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        self_ok); // R7
endmodule

// File: rtl/slice_remap_unit.sv
module slice_remap_unit #(
    parameter int ADDR_W     = 48,
    parameter int LINE_OFF_W = 6,
    parameter int SLICE_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    remap_en,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic [ADDR_W-1:0]       req_addr_i,
    output logic                    fwd_valid_o,
    input  logic                    fwd_ready_i,
    output logic [ADDR_W-1:0]       fwd_addr_o,
    output logic [SLICE_W-1:0]      fwd_dest_o,
    input  logic                    cfg_wr_en_i,
    input  logic [SLICE_W-1:0]      cfg_wr_idx_i,
    input  logic [SLICE_W-1:0]      cfg_wr_val_i,
    input  logic                    cfg_mask_wr_i,
    input  logic [(1<<SLICE_W)-1:0] cfg_mask_i,
    input  logic                    cfg_commit_i,
    output logic                    cfg_err_o
);
    localparam int NSLICE = 1 << SLICE_W;

    logic [NSLICE*SLICE_W-1:0] shadow_flat;
    logic [NSLICE-1:0]         shadow_mask;
    logic                      legal, accept, apply;
    logic [SLICE_W-1:0]        home_id, table_dest;

    assign home_id = req_addr_i[LINE_OFF_W +: SLICE_W];

    remap_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_touch (cfg_wr_en_i | cfg_mask_wr_i),
        .commit    (cfg_commit_i),
        .legal     (legal),
        .accept    (accept),
        .apply     (apply),
        .err       (cfg_err_o)
    );

    remap_shadow #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .wr_en       (cfg_wr_en_i),
        .wr_idx      (cfg_wr_idx_i),
        .wr_val      (cfg_wr_val_i),
        .mask_wr     (cfg_mask_wr_i),
        .mask_val    (cfg_mask_i),
        .shadow_flat (shadow_flat),
        .shadow_mask (shadow_mask),
        .legal       (legal)
    );

    remap_active #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_active (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (apply),
        .shadow_flat (shadow_flat),
        .shadow_mask (shadow_mask),
        .lookup_idx  (home_id),
        .lookup_dest (table_dest)
    );

    // zero-latency request path
    always_comb begin
        fwd_valid_o = req_valid_i;
        req_ready_o = fwd_ready_i;
        fwd_addr_o  = req_addr_i;
        fwd_dest_o  = remap_en ? table_dest : home_id;
    end
endmodule

// File: tb/slice_remap_unit_tb.sv
`timescale 1ns/1ps
module slice_remap_unit_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        remap_en = 0;
    logic        req_valid_i = 0;
    logic        req_ready_o;
    logic [47:0] req_addr_i = '0;
    logic        fwd_valid_o;
    logic        fwd_ready_i = 0;
    logic [47:0] fwd_addr_o;
    logic [3:0]  fwd_dest_o;
    logic        cfg_wr_en_i = 0;
    logic [3:0]  cfg_wr_idx_i = '0;
    logic [3:0]  cfg_wr_val_i = '0;
    logic        cfg_mask_wr_i = 0;
    logic [15:0] cfg_mask_i = '0;
    logic        cfg_commit_i = 0;
    logic        cfg_err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    slice_remap_unit dut_i (.*);

    // behavioural reference model
    int        m_sh[16];
    int        m_act[16];
    bit [15:0] m_shm, m_actm;
    bit        m_err, m_chk;

    function automatic bit m_legal();
        for (int j = 0; j < 16; j++) begin
            if (m_shm[j]) begin
                if (m_sh[j] != j) return 0;
            end else if (!m_shm[m_sh[j]]) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < 16; j++) begin m_sh[j] = j; m_act[j] = j; end
            m_shm = '1; m_actm = '1; m_err = 0; m_chk = 0;
        end else if (m_chk) begin
            if (m_legal()) begin
                for (int j = 0; j < 16; j++) m_act[j] = m_sh[j];
                m_actm = m_shm; m_err = 0;
            end else m_err = 1;
            m_chk = 0;
        end else begin
            if (cfg_wr_en_i) m_sh[int'(cfg_wr_idx_i)] = int'(cfg_wr_val_i);
            if (cfg_mask_wr_i) m_shm = cfg_mask_i;
            if (cfg_commit_i) m_chk = 1;
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int h;
            h = int'(req_addr_i[9:6]);
            chk(int'(fwd_dest_o), remap_en ? m_act[h] : h, remap_en ? "R1 dest" : "R2 bypass dest");
            chk(int'(fwd_addr_o == req_addr_i), 1, "R3 addr");
            chk(int'({fwd_valid_o, req_ready_o}), int'({req_valid_i, fwd_ready_i}), "R3 handshake");
            chk(int'(cfg_err_o), int'(m_err), "R8 err flag");
        end
    end

    task automatic cyc(input bit we, input int idx, input int val,
                       input bit mw, input logic [15:0] mv, input bit cm);
        @(posedge clk); #5;
        cfg_wr_en_i = we; cfg_wr_idx_i = 4'(idx); cfg_wr_val_i = 4'(val);
        cfg_mask_wr_i = mw; cfg_mask_i = mv; cfg_commit_i = cm;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, '0, 0); endtask

    function automatic logic [47:0] addr_of(input int s);
        return {$urandom(), 6'($urandom()), 4'(s), 6'($urandom())};
    endfunction

    task automatic look(input int s, input int exp, input string req);
        req_addr_i = addr_of(s);
        #1;
        chk(int'(fwd_dest_o), exp, req);
    endtask

    task automatic load_legal();
        logic [15:0] m;
        int alloc[$];
        m = 16'($urandom()) | (16'h1 << ($urandom() % 16));
        for (int j = 0; j < 16; j++) if (m[j]) alloc.push_back(j);
        cyc(0, 0, 0, 1, m, 0);
        for (int j = 0; j < 16; j++)
            cyc(1, j, m[j] ? j : alloc[$urandom() % alloc.size()], 0, '0, 0);
        cyc(0, 0, 0, 0, '0, 1);
        idle(); idle();
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fwd_ready_i = 1; req_valid_i = 1;
        repeat (3) @(posedge clk);
        #5 rst_n = 1; remap_en = 1;
        // R4: identity after reset
        for (int s = 0; s < 16; s++) look(s, s, "R4 identity");
        chk(int'(cfg_err_o), 0, "R4 err reset");
        // R5: shadow write invisible before commit
        cyc(1, 3, 0, 1, 16'hFFF7, 0);
        idle();
        look(3, 3, "R5 before commit");
        cyc(0, 0, 0, 0, '0, 1);
        look(3, 3, "R5 commit cycle");
        idle();
        look(3, 3, "R5 check cycle");
        idle();
        look(3, 0, "R1 remapped after apply");
        // R2: bypass
        remap_en = 0; look(3, 3, "R2 bypass"); remap_en = 1;
        // R7: allocated slice not self-mapped
        cyc(1, 0, 5, 0, '0, 0);
        cyc(0, 0, 0, 0, '0, 1);
        idle(); idle();
        chk(int'(cfg_err_o), 1, "R7 err set");
        look(0, 0, "R7 active kept");
        look(3, 0, "R7 active kept");
        // R8: sticky through writes
        cyc(1, 9, 9, 0, '0, 0); idle();
        chk(int'(cfg_err_o), 1, "R8 sticky after write");
        // R9: writes in check cycle ignored; then R8 clear
        cyc(1, 0, 0, 0, '0, 0);
        cyc(0, 0, 0, 0, '0, 1);
        cyc(1, 5, 0, 1, 16'hFFD7, 1);
        idle(); idle();
        chk(int'(cfg_err_o), 0, "R8 cleared by good commit");
        look(5, 5, "R9 write in check ignored");
        cyc(0, 0, 0, 0, '0, 1); idle(); idle();
        look(5, 5, "R9 shadow untouched");
        chk(int'(cfg_err_o), 0, "R9 mask write ignored");
        // R6: unallocated -> unallocated
        cyc(0, 0, 0, 1, 16'hFFF1, 0);
        cyc(1, 1, 2, 0, '0, 0);
        cyc(1, 2, 0, 0, '0, 0);
        cyc(1, 3, 2, 0, '0, 1);
        idle(); idle();
        chk(int'(cfg_err_o), 1, "R6 err set");
        look(1, 1, "R6 active kept");
        look(3, 0, "R6 active kept");
        // random phase against the model
        for (int n = 0; n < 40; n++) begin
            load_legal();
            for (int k = 0; k < 60; k++) begin
                cyc(($urandom() % 8) == 0, $urandom() % 16, $urandom() % 16,
                    ($urandom() % 16) == 0, 16'($urandom()) | 16'hF0F0,
                    ($urandom() % 10) == 0);
                remap_en    = ($urandom() % 6) != 0;
                req_valid_i = $urandom();
                fwd_ready_i = $urandom();
                req_addr_i  = addr_of($urandom() % 16);
            end
        end
        idle(); idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule